// File: doc/BRIEF.md
# Two-Slot Dual-Mono Audio Serial Port (Master)

This block is the master end of a two-timeslot serial audio link carrying 16-bit two's-complement samples. It divides the system clock into a bit clock and produces an alignment signal with 50% duty. The alignment signal is high for one 16-bit slot and low for the next, so each frame is 32 bit periods long and the frame rate is the sample rate. On the transmit line the same sample goes out in both slots, most significant bit first. On the receive line only the slot marked by the high alignment level is assembled into a word. The other slot is discarded.

Two static configuration inputs shape the timing. The first picks which bit-clock edge launches transmit data and alignment; receive data is always sampled on the other edge. The second picks whether the first data bit of a slot sits on the alignment change itself or one bit period later. In the late case, the last bit of each slot spills into the first bit period of the following slot. Configuration is expected to change only while reset is held.

Top module: `i2sdm_port`

## Requirements
- R1: While rst_n is low at a clock edge, the following edge leaves bclk_o, walign_o, sdata_o and rx_valid at 0 and rx_word at 0.
- R2: bclk_o toggles every HALF_DIV system clock cycles, giving a bit period of 2*HALF_DIV cycles with equal high and low phases.
- R3: walign_o changes only on launch edges. Within every frame it is high for exactly 16 consecutive bit periods and low for 16, and the first launch after reset starts a frame with walign_o rising.
- R4: With cfg_msb_delay=0, each slot carries the frame's transmit word on sdata_o, MSB in the first bit period of the slot (the bit period in which walign_o changes) and LSB in the 16th. The high slot and the low slot carry the same word.
- R5: With cfg_msb_delay=1, the MSB of each slot appears one bit period after the walign_o change. The remaining bits follow MSB first, so that the LSB lands in the first bit period of the next slot.
- R6: tx_word is latched on the launch edge where walign_o rises. Later changes to tx_word within that frame do not alter either slot of the frame.
- R7: With cfg_tx_fall=0, sdata_o and walign_o change only together with a rising edge of bclk_o. With cfg_tx_fall=1, they change only together with a falling edge.
- R8: sdata_i is sampled on the bclk_o edge opposite to the launch edge. A received word is assembled MSB first from the 16 bit periods of the high slot, and those bit periods are shifted by one when cfg_msb_delay=1.
- R9: rx_valid pulses for exactly one system clock cycle once per frame, on the capture edge of the high slot's LSB, with rx_word holding the assembled word. Data on sdata_i during the low slot does not affect rx_word.
- R10: With cfg_msb_delay=1, the first bit period of a frame carries bit 0 of the previous frame's latched word, even though a new word is latched on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_fall | input | 1 | 0: launch on bit-clock rise, sample on fall; 1: the reverse |
| cfg_msb_delay | input | 1 | 1: first data bit one bit period after the alignment change |
| tx_word | input | 16 | Sample to send in both slots of the next frame |
| sdata_i | input | 1 | Serial receive data |
| bclk_o | output | 1 | Bit clock |
| walign_o | output | 1 | Alignment signal, high for the first slot of each frame |
| sdata_o | output | 1 | Serial transmit data |
| rx_word | output | 16 | Last word received from the high slot |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_word |

## Verification
In the delayed mode, the launch edge that opens a frame has two jobs in one cycle. It latches the new transmit word, and it must still put out the previous word's LSB. The bench provokes this by changing tx_word every frame, well before that edge, so the old and new words differ in bit 0. It judges the result by comparing the first captured bit of each frame against the previous frame's expected word. The same frames also scramble tx_word in the middle of the high slot, which shows that both slots are served from the latched copy.

// File: rtl/i2sdm_pkg.sv
// Shared types for the two-slot dual-mono serial port.
// Assumes: nothing beyond the standard language.
package i2sdm_pkg;

    // One system-clock-wide markers for the two bit-clock edges of interest
    typedef struct packed {
        logic launch;   // edge on which data and alignment are driven
        logic capture;  // edge on which receive data is sampled
    } bit_edge_t;

    // Map raw rise/fall events onto launch/capture for the configured polarity
    function automatic bit_edge_t pick_edges(input logic rise,
                                             input logic fall,
                                             input logic tx_on_fall);
        bit_edge_t e;
        e.launch  = tx_on_fall ? fall : rise;
        e.capture = tx_on_fall ? rise : fall;
        return e;
    endfunction

endpackage

// File: rtl/i2sdm_bclk_gen.sv
// Bit-clock divider: toggles bclk every HALF_DIV system cycles and reports,
// one cycle wide, the edges that the register is about to make.
// Assumes: HALF_DIV >= 1; the edge markers are valid in the same cycle
// in which bclk is updated.
module i2sdm_bclk_gen
    import i2sdm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_on_fall,
    output logic      bclk,
    output bit_edge_t edges
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic toggle;

    generate
        if (HALF_DIV == 1) begin : g_every_cycle
            // Bit clock toggles on every system cycle
            assign toggle = 1'b1;
        end else begin : g_counted
            localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);
            logic [DIV_W-1:0] div_cnt;

            // Count system cycles within one half bit period
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                end else if (div_cnt == LAST) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end

            assign toggle = (div_cnt == LAST);
        end
    endgenerate

    // Bit clock register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk <= 1'b0;
        end else if (toggle) begin
            bclk <= ~bclk;
        end
    end

    // Classify the upcoming toggle as launch or capture
    always_comb begin
        edges = pick_edges(toggle & ~bclk, toggle & bclk, tx_on_fall);
    end

endmodule

// File: rtl/i2sdm_slot_seq.sv
// Frame sequencer: tracks the bit position within a 2*WORD_W frame and
// drives the alignment signal, high for the first slot.
// Assumes: WORD_W is a power of two; advances only on launch edges.
module i2sdm_slot_seq #(
    parameter int WORD_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch,
    output logic [$clog2(WORD_W):0]    pos,
    output logic [$clog2(WORD_W):0]    next_pos,
    output logic                       walign
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int POS_W = IDX_W + 1;

    // Wraps naturally because the frame length is a power of two
    assign next_pos = pos + POS_W'(1);

    // Position and alignment move together on each launch edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '1;
            walign <= 1'b0;
        end else if (launch) begin
            pos    <= next_pos;
            walign <= ~next_pos[POS_W-1];
        end
    end

endmodule

// File: rtl/i2sdm_tx_ser.sv
// Transmit serializer: latches one word per frame and sends it in both
// slots, MSB first, optionally one bit period late.
// Assumes: launch marks the edge on which sdata changes; next_pos is the
// position being entered on that edge.
module i2sdm_tx_ser #(
    parameter int WORD_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch,
    input  logic                       msb_delay,
    input  logic [$clog2(WORD_W):0]    next_pos,
    input  logic [WORD_W-1:0]          tx_word,
    output logic                       sdata,
    output logic [WORD_W-1:0]          frame_word
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int POS_W = IDX_W + 1;

    logic [POS_W-1:0]  drv_idx;
    logic [IDX_W-1:0]  bit_no;
    logic              frame_open;
    logic [WORD_W-1:0] src_word;

    // Choose which word bit belongs to the bit period being entered
    always_comb begin
        drv_idx    = msb_delay ? (next_pos - POS_W'(1)) : next_pos;
        bit_no     = ~drv_idx[IDX_W-1:0];
        frame_open = (next_pos == '0);
        // Undelayed: the fresh word starts now; delayed: old LSB goes out first
        src_word   = (frame_open && !msb_delay) ? tx_word : frame_word;
    end

    // Drive the data line and latch the frame word on launch edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata      <= 1'b0;
            frame_word <= '0;
        end else if (launch) begin
            sdata <= src_word[bit_no];
            if (frame_open) begin
                frame_word <= tx_word;
            end
        end
    end

endmodule

// File: rtl/i2sdm_rx_des.sv
// Receive deserializer: samples on capture edges, keeps only the bits of
// the high slot and strobes the finished word for one cycle.
// Assumes: pos is the position of the bit period being sampled.
module i2sdm_rx_des #(
    parameter int WORD_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic                       msb_delay,
    input  logic [$clog2(WORD_W):0]    pos,
    input  logic                       sdata,
    output logic [WORD_W-1:0]          rx_word,
    output logic                       rx_valid
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int POS_W = IDX_W + 1;

    logic [POS_W-1:0]  cap_idx;
    logic              in_high;
    logic              last_bit;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] next_word;

    // Locate the sampled bit inside the frame's slot layout
    always_comb begin
        cap_idx   = msb_delay ? (pos - POS_W'(1)) : pos;
        in_high   = ~cap_idx[POS_W-1];
        last_bit  = in_high && (&cap_idx[IDX_W-1:0]);
        next_word = {shreg[WORD_W-2:0], sdata};
    end

    // Shift in high-slot bits and publish the word after its LSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (capture && in_high) begin
                shreg <= next_word;
                if (last_bit) begin
                    rx_word  <= next_word;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2sdm_port.sv
// Top of the two-slot dual-mono serial port (bit-clock master).
// Assumes: cfg_tx_fall and cfg_msb_delay change only while rst_n is low;
// WORD_W is a power of two.
module i2sdm_port
    import i2sdm_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_fall,
    input  logic              cfg_msb_delay,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              sdata_i,
    output logic              bclk_o,
    output logic              walign_o,
    output logic              sdata_o,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int POS_W = $clog2(WORD_W) + 1;

    bit_edge_t         edges;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  next_pos;
    logic [WORD_W-1:0] frame_word;

    i2sdm_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_on_fall (cfg_tx_fall),
        .bclk       (bclk_o),
        .edges      (edges)
    );

    i2sdm_slot_seq #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (edges.launch),
        .pos      (pos),
        .next_pos (next_pos),
        .walign   (walign_o)
    );

    i2sdm_tx_ser #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (edges.launch),
        .msb_delay  (cfg_msb_delay),
        .next_pos   (next_pos),
        .tx_word    (tx_word),
        .sdata      (sdata_o),
        .frame_word (frame_word)
    );

    i2sdm_rx_des #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (edges.capture),
        .msb_delay (cfg_msb_delay),
        .pos       (pos),
        .sdata     (sdata_i),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

endmodule

// File: rtl/i2sdm_port_chk.sv
// Protocol checker for i2sdm_port, attached through bind.
// Assumes: configuration inputs are static outside reset.
module i2sdm_port_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_tx_fall,
    input logic              bclk_o,
    input logic              walign_o,
    input logic              sdata_o,
    input logic              rx_valid,
    input logic [WORD_W-1:0] frame_word
);

    // R7
    data_launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_o != $past(sdata_o)) |->
            ((bclk_o != $past(bclk_o)) && (bclk_o == !cfg_tx_fall)));

    // R3
    align_launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walign_o != $past(walign_o)) |->
            ((bclk_o != $past(bclk_o)) && (bclk_o == !cfg_tx_fall)));

    // R9
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    valid_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((bclk_o != $past(bclk_o)) && (bclk_o == cfg_tx_fall)));

    // R6
    word_latch_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_word != $past(frame_word)) |-> (walign_o && !$past(walign_o)));

endmodule

bind i2sdm_port i2sdm_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_tx_fall (cfg_tx_fall),
    .bclk_o      (bclk_o),
    .walign_o    (walign_o),
    .sdata_o     (sdata_o),
    .rx_valid    (rx_valid),
    .frame_word  (frame_word)
);

// File: tb/sim_i2sdm_port.sv
module sim_i2sdm_port;
    localparam int WW = 16;
    localparam int HD = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_tx_fall;
    logic          cfg_msb_delay;
    logic [WW-1:0] tx_word;
    logic          sdata_i;
    logic          bclk_o;
    logic          walign_o;
    logic          sdata_o;
    logic [WW-1:0] rx_word;
    logic          rx_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    i2sdm_port #(.WORD_W(WW), .HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_tx_fall(cfg_tx_fall),
        .cfg_msb_delay(cfg_msb_delay), .tx_word(tx_word), .sdata_i(sdata_i),
        .bclk_o(bclk_o), .walign_o(walign_o), .sdata_o(sdata_o),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] txw(input int n);
        return 16'h9A3C ^ 16'(n * 11093);
    endfunction
    function automatic logic [WW-1:0] rxw(input int n);
        return 16'h5E81 ^ 16'(n * 7919);
    endfunction

    task automatic do_reset(input logic fall, input logic dly);
        @(negedge clk);
        rst_n         = 1'b0;
        cfg_tx_fall   = fall;
        cfg_msb_delay = dly;
        tx_word       = txw(0);
        sdata_i       = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // R1: outputs while reset is held
    task automatic test_reset();
        do_reset(1'b0, 1'b0);
        chk(bclk_o == 1'b0,   "R1 bclk_o",   32'(bclk_o),   0);
        chk(walign_o == 1'b0, "R1 walign_o", 32'(walign_o), 0);
        chk(sdata_o == 1'b0,  "R1 sdata_o",  32'(sdata_o),  0);
        chk(rx_valid == 1'b0, "R1 rx_valid", 32'(rx_valid), 0);
        chk(rx_word == '0,    "R1 rx_word",  32'(rx_word),  0);
    endtask

    // Runs frames in one configuration and checks R2..R10 from the ports
    task automatic run_cfg(input logic fall, input logic dly, input int nframes);
        logic    prev_b, prev_wa, prev_sd;
        logic    cap [32];
        int      bpos = -1;
        int      frame = -1;
        int      hcount = 0, vcount = 0;
        int      half = 0, bad_half = 0, bad_edge = 0, first_edge = 1;
        int      cycles = 0;
        logic [WW-1:0] hi, lo, w;
        do_reset(fall, dly);
        rst_n   = 1'b1;
        prev_b  = bclk_o;
        prev_wa = walign_o;
        prev_sd = sdata_o;
        while (frame < nframes && cycles < 20000) begin
            logic b, ch, launch, capture;
            @(negedge clk);
            cycles++;
            half++;
            b       = bclk_o;
            ch      = (b != prev_b);
            launch  = ch && (fall ? !b : b);
            capture = ch && !launch;
            if (ch) begin
                if (!first_edge && half != HD) bad_half++;
                first_edge = 0;
                half = 0;
            end
            if ((sdata_o != prev_sd || walign_o != prev_wa) && !launch) bad_edge++;
            if (launch) begin
                if (walign_o && !prev_wa) begin
                    if (frame >= 0) begin
                        w = txw(frame);
                        for (int k = 0; k < 16; k++) begin
                            hi[15-k] = dly ? cap[k+1]  : cap[k];
                            lo[15-k] = dly ? ((k < 15) ? cap[k+17] : 1'b0) : cap[k+16];
                        end
                        if (dly) begin
                            chk(hi == w, "R5 high slot delayed", 32'(hi), 32'(w));
                            chk(lo[15:1] == w[15:1], "R5 low slot delayed",
                                32'(lo[15:1]), 32'(w[15:1]));
                        end else begin
                            chk(hi == w, "R4 high slot", 32'(hi), 32'(w));
                            chk(lo == w, "R4 R6 low slot", 32'(lo), 32'(w));
                        end
                        chk(hcount == 16, "R3 high bit periods", 32'(hcount), 16);
                        chk(vcount == 1, "R9 strobes per frame", 32'(vcount), 1);
                    end else begin
                        chk(bpos == -1, "R3 first launch opens frame", 32'(bpos), 32'hFFFFFFFF);
                    end
                    frame++;
                    bpos = 0;
                    hcount = 0;
                    vcount = 0;
                end else begin
                    bpos++;
                end
                if (walign_o) hcount++;
                if (bpos >= 0) begin
                    int idx;
                    logic [WW-1:0] junk;
                    idx  = dly ? ((bpos + 31) % 32) : bpos;
                    junk = ~rxw(frame);
                    sdata_i = (idx < 16) ? rxw(frame)[15-idx] : junk[31-idx];
                    // R6: scramble mid-frame, load next frame's word later
                    if (bpos == 5)  tx_word = 16'hDEAD ^ 16'(frame);
                    if (bpos == 20) tx_word = txw(frame + 1);
                end
            end
            if (capture && bpos >= 0) begin
                cap[bpos] = sdata_o;
                // R10: first bit period of a delayed frame holds previous LSB
                if (dly && bpos == 0 && frame >= 1)
                    chk(sdata_o == txw(frame - 1)[0], "R10 carried LSB",
                        32'(sdata_o), 32'(txw(frame - 1)[0]));
            end
            if (rx_valid) begin
                vcount++;
                chk(rx_word == rxw(frame), "R8 R9 received word",
                    32'(rx_word), 32'(rxw(frame)));
            end
            prev_b  = b;
            prev_wa = walign_o;
            prev_sd = sdata_o;
        end
        chk(frame == nframes, "R3 frames completed", 32'(frame), 32'(nframes));
        chk(bad_half == 0, "R2 half period length", 32'(bad_half), 0);
        chk(bad_edge == 0, "R7 changes off launch edge", 32'(bad_edge), 0);
    endtask

    task automatic test_rise_plain();  run_cfg(1'b0, 1'b0, 5); endtask
    task automatic test_fall_plain();  run_cfg(1'b1, 1'b0, 5); endtask
    task automatic test_rise_late();   run_cfg(1'b0, 1'b1, 5); endtask
    task automatic test_fall_late();   run_cfg(1'b1, 1'b1, 5); endtask

    initial begin
        rst_n = 1'b0; cfg_tx_fall = 1'b0; cfg_msb_delay = 1'b0;
        tx_word = '0; sdata_i = 1'b0;
        test_reset();
        test_rise_plain();
        test_fall_plain();
        test_rise_late();
        test_fall_late();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule